// File: doc/BRIEF.md
# Upset-Hardened Serial Command Decoder

This block takes serial commands on a bit line qualified by a frame signal and turns them into writes to a small bank of control registers and into steps of a receive-buffer write-address counter. Everything that holds state is kept as three independent copies: the sequencing state machine with its bit counter and shift register, each control register and the address counter. Every visible output is a bitwise two-out-of-three vote of the three copies.

A copy that an upset has corrupted is never repaired by the block itself. Control registers and the counter are put right only when the host writes them again or clears the counter. The sequencer copies reload their working state whenever they leave idle. A sticky flag reports any disagreement among the copies, and a read pulse clears it. Any state encoding the design does not use falls back to idle on the next clock, so an upset can never hang the sequencer.

For qualification, an upset port XORs a mask into any chosen subset of the copies of one target for one clock. The target can be a control register, the counter or the state.

Top module: `tmr_cmd_ctrl`

## Requirements
- R1: If exactly one copy of any register, counter or state bit is corrupted, the voted outputs `ctrl_o`, `wr_addr_o` and `busy_o` keep their correct values.
- R2: A command is a frame of bits sent MSB first while `frame_i` is high, one bit per clock. The first 5 bits are the header 5'b11101. Next come a 4-bit opcode and a 4-bit register address. Opcode 4'h1 (write) is followed by 16 data bits, and that data appears in `ctrl_o[16*addr +: 16]` once the frame completes.
- R3: Opcode 4'h2 adds one to `wr_addr_o`, opcode 4'h3 sets it to zero, and the counter wraps from 2^AW-1 to 0.
- R4: A frame whose header differs from 5'b11101 changes no register and does not move the counter.
- R5: If `frame_i` drops before a command is complete, the command is discarded and `busy_o` returns low.
- R6: A write to an address at or above NREG, or any opcode other than 4'h1, 4'h2 and 4'h3, changes neither `ctrl_o` nor `wr_addr_o`.
- R7: A state copy that holds an unused encoding returns to idle on the next clock. `busy_o` is high only while the voted state is not idle.
- R8: `mismatch_o` is set one clock after any voted bit has copies that disagree, and it stays set until a `flag_rd_i` pulse. A read pulse leaves it set while the disagreement persists, because no copy is corrected automatically. When two copies are corrupted alike, the voted output takes the corrupted value.
- R9: A host write command rewrites all three copies of a register, and a clear command rewrites all three copies of the counter. After that, a read pulse leaves `mismatch_o` low.
- R10: After reset, `ctrl_o`, `wr_addr_o`, `busy_o` and `mismatch_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | High while a command's bits are being sent |
| sdat_i | input | 1 | Serial command bit, MSB first |
| flag_rd_i | input | 1 | Read pulse that clears the mismatch flag |
| upset_en_i | input | 1 | Applies an upset mask on this clock |
| upset_copy_i | input | 3 | Selects the copies that receive the mask, one bit per copy |
| upset_tgt_i | input | TW (3) | Upset target: 0..NREG-1 is a register, NREG is the counter, NREG+1 is the state |
| upset_mask_i | input | DW (16) | XOR mask applied to the chosen target |
| ctrl_o | output | NREG*DW (64) | Voted control registers, register n in bits [16n +: 16] |
| wr_addr_o | output | AW (6) | Voted write-address counter |
| busy_o | output | 1 | Voted state is not idle |
| mismatch_o | output | 1 | Sticky flag for disagreement among the copies |

## Verification
The decoder is driven with valid write, step and clear frames. It also gets a frame with a wrong header, a frame cut short partway through its data, a write to an address beyond the bank and an unknown opcode. The good frames show the field order and timing. The broken ones show that only a complete, well-formed frame has any effect. The counter is stepped all the way around its range to catch the wrap. Upsets are applied to one copy and to two copies of a register, of the counter and of the state. These separate three cases: the vote masking an error, the flag catching an error the vote cannot mask, and the state falling back from an unused encoding. Rewrite commands followed by read pulses show that the flag clears only after the host has restored the copies.

// File: rtl/tmr_cmd_pkg.sv
package tmr_cmd_pkg;
   localparam int         ST_W     = 3;
   localparam logic [2:0] ST_IDLE  = 3'd0;
   localparam logic [2:0] ST_HDR   = 3'd1;
   localparam logic [2:0] ST_OPC   = 3'd2;
   localparam logic [2:0] ST_ADR   = 3'd3;
   localparam logic [2:0] ST_DAT   = 3'd4;
   localparam logic [2:0] ST_EXE   = 3'd5;

   localparam int         HDR_LEN  = 5;
   localparam int         OPC_LEN  = 4;
   localparam int         ADR_LEN  = 4;
   localparam logic [4:0] HDR_CODE = 5'b11101;

   localparam logic [3:0] OP_WRITE = 4'h1;
   localparam logic [3:0] OP_STEP  = 4'h2;
   localparam logic [3:0] OP_CLEAR = 4'h3;

   localparam int         CNT_W    = 5;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] y_o
);
   for (genvar k = 0; k < W; k++) begin : g_bit
      assign y_o[k] = (a_i[k] & b_i[k]) | (a_i[k] & c_i[k]) | (b_i[k] & c_i[k]);
   end
endmodule

// File: rtl/tmr_cmd_flag.sv
module tmr_cmd_flag #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         rd_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic         flag_o
);
   logic differ;
   logic flag_q;

   assign differ = |((a_i ^ b_i) | (a_i ^ c_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   flag_q <= 1'b0;
      else if (rd_i) flag_q <= differ;
      else           flag_q <= flag_q | differ;
   end

   assign flag_o = flag_q;

   a_r8_set_on_differ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      differ |=> flag_o);
   a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !rd_i) |=> flag_o);
   a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !differ) |=> !flag_o);
endmodule

// File: rtl/tmr_cmd_copy.sv
module tmr_cmd_copy
   import tmr_cmd_pkg::*;
#(
   parameter int NREG = 4,
   parameter int DW   = 16,
   parameter int AW   = 6,
   parameter int TW   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_i,
   input  logic              sdat_i,
   input  logic              inj_i,
   input  logic [TW-1:0]     inj_tgt_i,
   input  logic [DW-1:0]     inj_mask_i,
   output logic [NREG*DW-1:0] regs_o,
   output logic [AW-1:0]     addr_o,
   output logic [ST_W-1:0]   st_o
);
   localparam logic [TW-1:0] TGT_CNT = TW'(NREG);
   localparam logic [TW-1:0] TGT_ST  = TW'(NREG + 1);

   logic [ST_W-1:0]  st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
   logic [DW-1:0]    sh_q, sh_d, sh_nx;
   logic [3:0]       op_q, op_d, ad_q, ad_d;
   logic             frm_q;
   logic [AW-1:0]    addr_q, addr_d;
   logic [DW-1:0]    reg_q [NREG];
   logic [DW-1:0]    reg_d [NREG];
   logic             last;

   assign sh_nx = {sh_q[DW-2:0], sdat_i};

   always_comb begin
      case (st_q)
         ST_HDR:  last_idx = CNT_W'(HDR_LEN - 1);
         ST_OPC:  last_idx = CNT_W'(OPC_LEN - 1);
         ST_ADR:  last_idx = CNT_W'(ADR_LEN - 1);
         ST_DAT:  last_idx = CNT_W'(DW - 1);
         default: last_idx = '0;
      endcase
   end
   assign last = (cnt_q == last_idx);

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      sh_d   = sh_q;
      op_d   = op_q;
      ad_d   = ad_q;
      addr_d = addr_q;
      for (int r = 0; r < NREG; r++) reg_d[r] = reg_q[r];
      case (st_q)
         ST_IDLE: begin
            if (frame_i && !frm_q) begin
               st_d  = ST_HDR;
               cnt_d = CNT_W'(1);
               sh_d  = sh_nx;
            end
         end
         ST_HDR, ST_OPC, ST_ADR, ST_DAT: begin
            if (!frame_i) begin
               st_d = ST_IDLE;
            end else begin
               sh_d  = sh_nx;
               cnt_d = cnt_q + CNT_W'(1);
               if (last) begin
                  cnt_d = '0;
                  case (st_q)
                     ST_HDR:  st_d = (sh_nx[4:0] == HDR_CODE) ? ST_OPC : ST_IDLE;
                     ST_OPC:  begin op_d = sh_nx[3:0]; st_d = ST_ADR; end
                     ST_ADR:  begin
                        ad_d = sh_nx[3:0];
                        st_d = (op_q == OP_WRITE) ? ST_DAT : ST_EXE;
                     end
                     default: st_d = ST_EXE;
                  endcase
               end
            end
         end
         ST_EXE: begin
            st_d = ST_IDLE;
            case (op_q)
               OP_WRITE: for (int r = 0; r < NREG; r++)
                            if (ad_q == 4'(r)) reg_d[r] = sh_q;
               OP_STEP:  addr_d = addr_q + AW'(1);
               OP_CLEAR: addr_d = '0;
               default:  ;
            endcase
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         op_q   <= '0;
         ad_q   <= '0;
         frm_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         st_q   <= st_d ^ ((inj_i && inj_tgt_i == TGT_ST) ? inj_mask_i[ST_W-1:0] : '0);
         addr_q <= addr_d ^ ((inj_i && inj_tgt_i == TGT_CNT) ? inj_mask_i[AW-1:0] : '0);
         cnt_q  <= cnt_d;
         sh_q   <= sh_d;
         op_q   <= op_d;
         ad_q   <= ad_d;
         frm_q  <= frame_i;
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) reg_q[g] <= '0;
         else         reg_q[g] <= reg_d[g] ^ ((inj_i && inj_tgt_i == TW'(g)) ? inj_mask_i : '0);
      end
      assign regs_o[g*DW +: DW] = reg_q[g];
   end

   assign addr_o = addr_q;
   assign st_o   = st_q;

   a_r7_unused_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q > ST_EXE && !inj_i) |=> (st_q == ST_IDLE));
   a_r5_drop_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q >= ST_HDR && st_q <= ST_DAT && !frame_i && !inj_i) |=> (st_q == ST_IDLE));
   a_r3_step_adds_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_EXE && op_q == OP_STEP && !inj_i) |=> (addr_q == $past(addr_q) + AW'(1)));
   a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_EXE && op_q == OP_CLEAR && !inj_i) |=> (addr_q == '0));
endmodule

// File: rtl/tmr_cmd_ctrl.sv
module tmr_cmd_ctrl
   import tmr_cmd_pkg::*;
#(
   parameter int NREG = 4,
   parameter int DW   = 16,
   parameter int AW   = 6,
   parameter int TW   = $clog2(NREG + 2)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               frame_i,
   input  logic               sdat_i,
   input  logic               flag_rd_i,
   input  logic               upset_en_i,
   input  logic [2:0]         upset_copy_i,
   input  logic [TW-1:0]      upset_tgt_i,
   input  logic [DW-1:0]      upset_mask_i,
   output logic [NREG*DW-1:0] ctrl_o,
   output logic [AW-1:0]      wr_addr_o,
   output logic               busy_o,
   output logic               mismatch_o
);
   localparam int RW = NREG * DW;
   localparam int VW = RW + AW + ST_W;

   if (DW < HDR_LEN || DW > 16) begin : g_bad_dw
      $error("tmr_cmd_ctrl: DW must lie in 5..16");
   end
   if (NREG < 1 || NREG > 16) begin : g_bad_nreg
      $error("tmr_cmd_ctrl: NREG must lie in 1..16");
   end
   if (AW < 1 || AW > DW) begin : g_bad_aw
      $error("tmr_cmd_ctrl: AW must lie in 1..DW");
   end
   if (TW < $clog2(NREG + 2)) begin : g_bad_tw
      $error("tmr_cmd_ctrl: TW too narrow for the upset targets");
   end

   logic [VW-1:0]   word [3];
   logic [VW-1:0]   voted;
   logic [ST_W-1:0] st_v;

   for (genvar i = 0; i < 3; i++) begin : g_copy
      logic [RW-1:0]   regs;
      logic [AW-1:0]   addr;
      logic [ST_W-1:0] st;
      tmr_cmd_copy #(.NREG(NREG), .DW(DW), .AW(AW), .TW(TW)) u_copy (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .frame_i    (frame_i),
         .sdat_i     (sdat_i),
         .inj_i      (upset_en_i & upset_copy_i[i]),
         .inj_tgt_i  (upset_tgt_i),
         .inj_mask_i (upset_mask_i),
         .regs_o     (regs),
         .addr_o     (addr),
         .st_o       (st)
      );
      assign word[i] = {st, addr, regs};
   end

   tmr_vote #(.W(VW)) u_vote (
      .a_i (word[0]),
      .b_i (word[1]),
      .c_i (word[2]),
      .y_o (voted)
   );

   tmr_cmd_flag #(.W(VW)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rd_i   (flag_rd_i),
      .a_i    (word[0]),
      .b_i    (word[1]),
      .c_i    (word[2]),
      .flag_o (mismatch_o)
   );

   assign ctrl_o    = voted[RW-1:0];
   assign wr_addr_o = voted[RW +: AW];
   assign st_v      = voted[VW-1 -: ST_W];
   assign busy_o    = (st_v != ST_IDLE);

   a_r1_single_copy_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word[0] == word[1] && word[1] != word[2]) |-> (ctrl_o == word[0][RW-1:0]));
   a_r8_unanimous_no_new_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mismatch_o && word[0] == word[1] && word[1] == word[2]) |=> !mismatch_o);
endmodule

// File: tb/tmr_cmd_ctrl_tb_top.sv
module tmr_cmd_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 4;
   localparam int DW   = 16;
   localparam int AW   = 6;
   localparam int TW   = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               frame = 1'b0, sdat = 1'b0, flag_rd = 1'b0;
   logic               up_en = 1'b0;
   logic [2:0]         up_copy = '0;
   logic [TW-1:0]      up_tgt = '0;
   logic [DW-1:0]      up_mask = '0;
   logic [NREG*DW-1:0] ctrl;
   logic [AW-1:0]      wr_addr;
   logic               busy, mismatch;
   int                 checks = 0, errors = 0;
   bit                 done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_cmd_ctrl #(.NREG(NREG), .DW(DW), .AW(AW), .TW(TW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .sdat_i(sdat),
      .flag_rd_i(flag_rd), .upset_en_i(up_en), .upset_copy_i(up_copy),
      .upset_tgt_i(up_tgt), .upset_mask_i(up_mask),
      .ctrl_o(ctrl), .wr_addr_o(wr_addr), .busy_o(busy), .mismatch_o(mismatch));

   function automatic logic [15:0] reg_of(input int a);
      return ctrl[a*16 +: 16];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Sends a frame; stop_at >= 0 drops frame_i after that many bits.
   task automatic send(input logic [4:0] hdr, input logic [3:0] op, input logic [3:0] ad,
                       input logic [15:0] dat, input int stop_at);
      logic [28:0] bits;
      int n;
      bits = {hdr, op, ad, dat};
      n = (op == 4'h1) ? 29 : 13;
      for (int i = 0; i < n; i++) begin
         if (i == stop_at) break;
         @(negedge clk); frame = 1'b1; sdat = bits[28-i];
      end
      @(negedge clk);
      if (stop_at >= 0) check("R5 busy before drop", busy, 1'b1);
      frame = 1'b0; sdat = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      send(5'b11101, 4'h1, 4'(a), d, -1);
   endtask

   task automatic upset(input logic [2:0] copies, input int tgt, input logic [15:0] m);
      @(negedge clk); up_en = 1'b1; up_copy = copies; up_tgt = TW'(tgt); up_mask = m;
      @(negedge clk); up_en = 1'b0; up_copy = '0; up_mask = '0;
      @(negedge clk);
   endtask

   task automatic read_flag();
      @(negedge clk); flag_rd = 1'b1;
      @(negedge clk); flag_rd = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 ctrl", ctrl[31:0], 32'h0);
      check("R10 ctrl hi", ctrl[63:32], 32'h0);
      check("R10 addr", 32'(wr_addr), 0);
      check("R10 busy", busy, 1'b0);
      check("R10 flag", mismatch, 1'b0);
   endtask

   task automatic t_write();
      wr(1, 16'hA5C3);
      check("R2 reg1", reg_of(1), 16'hA5C3);
      wr(3, 16'h1234);
      check("R2 reg3", reg_of(3), 16'h1234);
      check("R2 reg0 untouched", reg_of(0), 16'h0);
   endtask

   task automatic t_counter();
      for (int i = 0; i < 3; i++) send(5'b11101, 4'h2, 4'h0, 16'h0, -1);
      check("R3 step x3", 32'(wr_addr), 3);
      send(5'b11101, 4'h3, 4'h0, 16'h0, -1);
      check("R3 clear", 32'(wr_addr), 0);
      for (int i = 0; i < 64; i++) send(5'b11101, 4'h2, 4'h0, 16'h0, -1);
      check("R3 wrap", 32'(wr_addr), 0);
      send(5'b11101, 4'h2, 4'h0, 16'h0, -1);
      check("R3 after wrap", 32'(wr_addr), 1);
   endtask

   task automatic t_bad_frames();
      send(5'b11100, 4'h1, 4'h1, 16'hFFFF, -1);
      check("R4 bad header reg1", reg_of(1), 16'hA5C3);
      send(5'b01101, 4'h2, 4'h0, 16'h0, -1);
      check("R4 bad header addr", 32'(wr_addr), 1);
      send(5'b11101, 4'h1, 4'h0, 16'hBEEF, 20);
      check("R5 dropped write", reg_of(0), 16'h0);
      check("R5 busy after drop", busy, 1'b0);
      send(5'b11101, 4'h1, 4'h9, 16'h7777, -1);
      check("R6 addr>=NREG lo", ctrl[31:0], {16'hA5C3, 16'h0});
      check("R6 addr>=NREG hi", ctrl[63:32], {16'h1234, 16'h0});
      send(5'b11101, 4'hF, 4'h1, 16'h0, -1);
      check("R6 unknown op addr", 32'(wr_addr), 1);
      check("R6 unknown op reg1", reg_of(1), 16'hA5C3);
      check("R8 no flag so far", mismatch, 1'b0);
   endtask

   task automatic t_single_upsets();
      upset(3'b001, 1, 16'hFFFF);
      check("R1 reg1 masked", reg_of(1), 16'hA5C3);
      check("R8 flag set", mismatch, 1'b1);
      read_flag();
      check("R8 flag held while differing", mismatch, 1'b1);
      wr(1, 16'hA5C3);
      read_flag();
      check("R9 flag clear after rewrite", mismatch, 1'b0);
      upset(3'b100, 4, 16'h003F);
      check("R1 counter masked", 32'(wr_addr), 1);
      send(5'b11101, 4'h3, 4'h0, 16'h0, -1);
      read_flag();
      check("R9 flag clear after counter clear", mismatch, 1'b0);
   endtask

   task automatic t_double_upset();
      upset(3'b011, 3, 16'h0001);
      check("R8 two copies win vote", reg_of(3), 16'h1235);
      check("R8 flag on double", mismatch, 1'b1);
      wr(3, 16'h1234);
      check("R9 reg3 restored", reg_of(3), 16'h1234);
      read_flag();
      check("R9 flag cleared", mismatch, 1'b0);
   endtask

   task automatic t_state_upsets();
      upset(3'b010, 5, 16'h0007);
      check("R1 single state flip busy", busy, 1'b0);
      read_flag();
      check("R7 lone state copy back to idle", mismatch, 1'b0);
      @(negedge clk); up_en = 1'b1; up_copy = 3'b101; up_tgt = TW'(5); up_mask = 16'h0007;
      @(negedge clk); up_en = 1'b0; up_copy = '0; up_mask = '0;
      check("R7 voted unused state busy", busy, 1'b1);
      @(negedge clk);
      check("R7 back to idle", busy, 1'b0);
      read_flag();
      check("R7 copies agree again", mismatch, 1'b0);
      wr(2, 16'h0F0F);
      check("R7 decoder still works", reg_of(2), 16'h0F0F);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_counter();
      t_bad_frames();
      t_single_upsets();
      t_double_upset();
      t_state_upsets();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule